// File: doc/BRIEF.md
# Sequenced Software Watchdog

This block is a watchdog timer that runs from the system clock and raises a one-cycle time-out request when software fails to restart it in time. The time-out length is set by two settings. One turns on a fixed pre-divider. The other is a two-bit period selector. To restart the count, software writes a two-value key sequence to a service address. Any amount of other bus traffic may fall between the two key writes.

Settings are written into a configuration register through a plain write port that has an address and a data byte. The port accepts a write on every cycle and has no back-pressure. The enable bit acts at once. The pre-divider bit and the period selector are only held as pending values, and they are copied into the live timing on the next completed key sequence. A strap input chooses the reset value of the pre-divider bit, so a part running from an external clock starts with the longer time-outs.

Top module: `wdog_svc_top`

## Requirements
- R1: After a synchronous reset, `timeout_o` is low and the live configuration holds these values: enable 1, period selector 0, pre-divider bit equal to the inverse of `strap_int_clk`. With the strap high, the first time-out pulse arrives 2^BASE_LOG2 clocks after reset is released.
- R2: A write of 8'h55 to address 1 followed later by a write of 8'hAA to address 1 is a completed service. It clears the count, so that the next pulse comes one full period after the 8'hAA write. A time-out that falls due in the same cycle as the service is dropped.
- R3: Writes to other addresses, including configuration writes to address 0, may sit between 8'h55 and 8'hAA without breaking the sequence.
- R4: A write of 8'hAA to address 1 that does not follow an arming 8'h55 does not service. Any value other than 8'h55 or 8'hAA written to address 1 while armed disarms the block. A repeated 8'h55 keeps it armed.
- R5: When the count reaches the live period, `timeout_o` is high for exactly one clock and counting restarts from zero.
- R6: The period in enabled clocks is 2^(BASE_LOG2 + STEP_LOG2*sel). When the pre-divider bit is 1, this is multiplied by 2^PRE_LOG2.
- R7: A configuration write to address 0 places the enable bit in bit 0, the pre-divider bit in bit 1 and the period selector in bits 3:2. The new pre-divider and period values take no effect until the next completed service, and the old period remains in use until then.
- R8: While the enable bit is 0, the count and the pre-divider stay frozen and no pulse is produced.
- R9: With `strap_int_clk` low at reset, the pre-divider starts at 1, and the first pulse arrives 2^(BASE_LOG2+PRE_LOG2) clocks after reset is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_int_clk | input | 1 | Clock-mode strap. High means internal clock, which gives no pre-divide at reset |
| wr_en | input | 1 | Write strobe. Always accepted |
| wr_addr | input | ADDR_W | Write address: 0 is configuration, 1 is service key |
| wr_data | input | 8 | Write data |
| timeout_o | output | 1 | One-cycle time-out request |

## Verification
The bench checks that a new period is deferred. It writes a new selector and confirms that the old period still measures until a key sequence completes. A design that applied the selector at once would shorten or lengthen that interval. It sends a bare 8'hAA, a disarming value after 8'h55, and a doubled 8'h55. It then checks the remaining time to the next pulse, which is one period less the cycles used, or a full period. A design with a loose sequence checker would restart when it should not, or fail to restart when it should. It also places configuration writes and a stray address between the keys, strap-selects the prescaled start, and holds the enable low for a long stretch. A design that broke on foreign writes, ignored the strap or kept counting while disabled would move or add pulses.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int CFG_ADDR = 0;
  localparam int SVC_ADDR = 1;
  localparam logic [7:0] KEY_ARM  = 8'h55;
  localparam logic [7:0] KEY_FIRE = 8'hAA;
  localparam int EN_BIT  = 0;
  localparam int PRE_BIT = 1;
  localparam int SEL_LO  = 2;

  typedef struct packed {
    logic       pre;
    logic [1:0] sel;
  } wd_timing_t;
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler #(
  parameter int PRE_LOG2 = 9
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic div_on,
  input  logic restart,
  output logic tick
);
  logic [PRE_LOG2-1:0] pcnt;

  assign tick = en & (~div_on | (&pcnt));

  always_ff @(posedge clk) begin
    if (rst || restart) pcnt <= '0;
    else if (en && div_on) pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/wdog_svc_seq.sv
module wdog_svc_seq (
  input  logic       clk,
  input  logic       rst,
  input  logic       svc_wr,
  input  logic [7:0] data,
  output logic       svc_done
);
  import wdog_pkg::*;
  logic armed;

  assign svc_done = svc_wr & armed & (data == KEY_FIRE);

  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else if (svc_wr) armed <= (data == KEY_ARM);
  end
endmodule

// File: rtl/wdog_period_cnt.sv
module wdog_period_cnt #(
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       restart,
  input  logic [1:0] sel,
  output logic       expire
);
  localparam int CNT_W = BASE_LOG2 + 3 * STEP_LOG2;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last_val;
  logic [CNT_W:0]   span;

  always_comb begin
    span     = (CNT_W+1)'(1) << (BASE_LOG2 + STEP_LOG2 * int'(sel));
    last_val = CNT_W'(span - 1'b1);
  end

  assign expire = tick & (cnt == last_val);

  always_ff @(posedge clk) begin
    if (rst || restart || expire) cnt <= '0;
    else if (tick) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/wdog_svc_top.sv
module wdog_svc_top #(
  parameter int BASE_LOG2 = 9,
  parameter int STEP_LOG2 = 2,
  parameter int PRE_LOG2  = 9,
  parameter int ADDR_W    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strap_int_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic              timeout_o
);
  import wdog_pkg::*;

  logic       en_q;
  wd_timing_t pend_q, live_q;
  logic       cfg_wr, svc_wr, svc_done, tick, expire, restart;

  assign cfg_wr  = wr_en & (wr_addr == ADDR_W'(CFG_ADDR));
  assign svc_wr  = wr_en & (wr_addr == ADDR_W'(SVC_ADDR));
  assign restart = svc_done | expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= 1'b1;
      pend_q <= '{pre: ~strap_int_clk, sel: 2'd0};
      live_q <= '{pre: ~strap_int_clk, sel: 2'd0};
    end else begin
      if (cfg_wr) begin
        en_q       <= wr_data[EN_BIT];
        pend_q.pre <= wr_data[PRE_BIT];
        pend_q.sel <= wr_data[SEL_LO+1:SEL_LO];
      end
      if (svc_done) live_q <= pend_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) timeout_o <= 1'b0;
    else     timeout_o <= expire & ~svc_done;
  end

  wdog_svc_seq u_seq (
    .clk(clk), .rst(rst), .svc_wr(svc_wr), .data(wr_data), .svc_done(svc_done)
  );

  wdog_prescaler #(.PRE_LOG2(PRE_LOG2)) u_pre (
    .clk(clk), .rst(rst), .en(en_q), .div_on(live_q.pre),
    .restart(restart), .tick(tick)
  );

  wdog_period_cnt #(.BASE_LOG2(BASE_LOG2), .STEP_LOG2(STEP_LOG2)) u_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(svc_done),
    .sel(live_q.sel), .expire(expire)
  );
endmodule

// File: rtl/wdog_svc_chk.sv
module wdog_svc_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic              svc_done,
  input logic              en_q,
  input logic [2:0]        live_bits,
  input logic              timeout_o
);
  import wdog_pkg::*;
  logic svc_wr;
  assign svc_wr = wr_en && (wr_addr == ADDR_W'(SVC_ADDR));

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    timeout_o |=> !timeout_o); // R5
  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> !timeout_o); // R8
  AST_SVC_BEATS_EXPIRE: assert property (@(posedge clk) disable iff (rst)
    svc_done |=> !timeout_o); // R2
  AST_ARM_THEN_FIRE: assert property (@(posedge clk) disable iff (rst)
    (svc_wr && wr_data == KEY_FIRE && $past(svc_wr && wr_data == KEY_ARM)) |-> svc_done); // R4
  AST_BARE_FIRE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (svc_wr && wr_data == KEY_FIRE && $past(svc_wr && wr_data != KEY_ARM)) |-> !svc_done); // R4
  AST_LIVE_HELD: assert property (@(posedge clk) disable iff (rst)
    !svc_done |=> $stable(live_bits)); // R7
endmodule

bind wdog_svc_top wdog_svc_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .svc_done(svc_done), .en_q(en_q), .live_bits(live_q), .timeout_o(timeout_o)
);

// File: tb/wdog_svc_top_tb.sv
module wdog_svc_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int B = 3, S = 2, P = 2, AW = 4;

  logic clk = 1'b0, rst = 1'b1, strap = 1'b1, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic timeout_o;

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  wdog_svc_top #(.BASE_LOG2(B), .STEP_LOG2(S), .PRE_LOG2(P), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .strap_int_clk(strap), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .timeout_o(timeout_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int period_of(bit pre, int sel);
    return 1 << (B + S * sel + (pre ? P : 0));
  endfunction

  // behavioural reference
  bit m_en, m_ppre, m_lpre, m_armed, m_exp;
  int m_psel, m_lsel, m_elapsed;
  always @(posedge clk) begin
    if (rst) begin
      m_en = 1; m_ppre = !strap; m_lpre = !strap; m_psel = 0; m_lsel = 0;
      m_armed = 0; m_elapsed = 0; m_exp = 0;
    end else begin
      bit svc;
      svc = wr_en && wr_addr == 1 && wr_data == 8'hAA && m_armed;
      m_exp = 0;
      if (svc) begin
        m_elapsed = 0; m_lpre = m_ppre; m_lsel = m_psel;
      end else if (m_en) begin
        m_elapsed++;
        if (m_elapsed == period_of(m_lpre, m_lsel)) begin m_exp = 1; m_elapsed = 0; end
      end
      if (wr_en && wr_addr == 1) m_armed = (wr_data == 8'h55);
      if (wr_en && wr_addr == 0) begin
        m_en = wr_data[0]; m_ppre = wr_data[1]; m_psel = int'(wr_data[3:2]);
      end
    end
  end

  always @(negedge clk) begin
    checks++;
    if (timeout_o !== m_exp) begin
      fails++;
      $display("FAIL %s cycle compare: timeout_o actual %b expected %b", cur_req, timeout_o, m_exp);
    end
  end

  task automatic check_int(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(bit s);
    strap = s; rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
  endtask

  task automatic wr(int a, logic [7:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic measure(output int n);
    n = 0;
    while (!timeout_o && n < 20000) begin @(negedge clk); n++; end
  endtask

  task automatic wait_pulse();
    int n;
    measure(n);
  endtask

  task automatic gap(output int n);
    @(negedge clk);
    n = 1;
    while (!timeout_o && n < 20000) begin @(negedge clk); n++; end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    int n, pulses;
    @(negedge clk);
    cur_req = "R1";
    do_reset(1'b1);
    check_int("R1 reset output", int'(timeout_o), 0);
    measure(n); check_int("R1 default period", n, period_of(0, 0));

    cur_req = "R9";
    do_reset(1'b0);
    measure(n); check_int("R9 strap low prescaled", n, period_of(1, 0));

    cur_req = "R7";
    do_reset(1'b1);
    wr(0, 8'h09);
    wait_pulse();
    gap(n); check_int("R7 old period kept", n, period_of(0, 0));

    cur_req = "R2";
    wr(1, 8'h55); wr(1, 8'hAA);
    measure(n); check_int("R2 R6 service applies sel 2", n, period_of(0, 2));

    cur_req = "R3";
    wr(1, 8'h55); wr(0, 8'h03); wr(5, 8'hAA); wr(1, 8'hAA);
    measure(n); check_int("R3 foreign writes tolerated", n, period_of(1, 0));

    cur_req = "R5";
    @(negedge clk);
    check_int("R5 pulse one cycle", int'(timeout_o), 0);

    cur_req = "R4";
    wait_pulse(); wr(1, 8'hAA);
    measure(n); check_int("R4 bare fire ignored", n, period_of(1, 0) - 1);
    wait_pulse(); wr(1, 8'h55); wr(1, 8'h12); wr(1, 8'hAA);
    measure(n); check_int("R4 disarm by other value", n, period_of(1, 0) - 3);
    wait_pulse(); wr(1, 8'h55); wr(1, 8'h55); wr(1, 8'hAA);
    measure(n); check_int("R4 repeated arm holds", n, period_of(1, 0));

    cur_req = "R8";
    wr(0, 8'h02);
    pulses = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (timeout_o) pulses++; end
    check_int("R8 no pulse while disabled", pulses, 0);
    wr(0, 8'h01);

    cur_req = "R6";
    wr(0, 8'h0F); wr(1, 8'h55); wr(1, 8'hAA);
    measure(n); check_int("R6 largest prescaled period", n, period_of(1, 3));
    gap(n); check_int("R5 R6 period repeats", n, period_of(1, 3));

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule